// File: doc/BRIEF.md
# GPIO Trigger Detector Interrupt Unit

This block watches a port of general-purpose input pins and turns pin activity into interrupt and wake requests. Each pin is first brought into the local clock domain. It is then compared against a per-pin rule. The rule picks level or edge detection, which edge or which level counts, and whether any change at all counts. When the rule matches, the pin's pending bit is set and stays set until software clears it by writing a one to that bit.

The pins are split into groups of sixteen, and each group has its own interrupt request line. A line is high while any pin in its group has both its pending bit and its enable bit set. A single wake line is high while any pin has both its pending bit and its wake-enable bit set.

Software reaches six per-pin control words through a word-addressed write port with a combinational read port. Each word has one bit per pin, and pin n is bit n.

Top module: `gpev_top`

## Requirements
- R1: After reset every control word reads zero, all pending bits are clear, and every interrupt and wake output is low.
- R2: The words are placed as follows: interrupt enable at offset 0x00, pending at 0x10, any-change at 0x20, level select at 0x30, polarity at 0x40 and wake enable at 0x50. Written values read back at the same offset. Any other offset reads zero, and a write to it changes no word.
- R3: With level select at 0 and any-change at 0, a polarity bit of 1 detects rising edges only and a polarity bit of 0 detects falling edges only. The opposite edge sets nothing.
- R4: With level select at 0 and any-change at 1, both rising and falling edges set the pending bit, whatever the polarity bit holds.
- R5: With level select at 1, the pending bit is set on every cycle the synchronised input equals the polarity bit (1 means high, 0 means low). It cannot be cleared while that level persists.
- R6: In the pending word, writing 1 to a bit clears it and writing 0 leaves it unchanged. If a new event and a clear reach the same bit in the same cycle, the bit stays set.
- R7: A pending bit is set by an event whether or not the pin's interrupt enable bit is set.
- R8: irq_req[0] is high exactly when some pin 0–15 has both its pending and enable bits set. irq_req[1] does the same for pins 16–31.
- R9: wake_req is high exactly when some pin has both its pending and wake-enable bits set.
- R10: A pin change that meets the rule shows in the pending word on the third rising clock edge after the change, because of the two-flop synchroniser. It is not yet visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req | output | 2 | Interrupt request per group of sixteen pins |
| wake_req | output | 1 | Wake request |

## Verification
A pin change presented on a falling clock edge passes two synchroniser flops and the pending register. It is due in the pending word, on the interrupt lines and on the wake line after the third rising edge. The latency check therefore reads the pending word once at the falling edge after the second rising edge, where it must still be clear, and once after the third, where it must be set. A register write takes effect at the rising edge at which it is presented, and the interrupt and wake outputs follow that edge combinationally. Every other check waits at least four edges after a pin change or one edge after a write, and samples on a falling edge.

// File: rtl/gpev_pkg.sv
package gpev_pkg;

  // byte distance between consecutive control words
  localparam int unsigned REG_STRIDE = 16;
  localparam int unsigned NUM_REGS   = 6;

  // slot index of each control word (offset = index * REG_STRIDE)
  localparam int unsigned IDX_IEN  = 0;
  localparam int unsigned IDX_PEND = 1;
  localparam int unsigned IDX_CHG  = 2;
  localparam int unsigned IDX_LVL  = 3;
  localparam int unsigned IDX_POL  = 4;
  localparam int unsigned IDX_WAKE = 5;

  // detection rule for one pin
  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic lvl, input logic chg,
                                     input logic pol);
    logic hit;
    if (lvl)       hit = (cur == pol);
    else if (chg)  hit = (cur != prev);
    else if (pol)  hit = cur & ~prev;
    else           hit = ~cur & prev;
    return hit;
  endfunction

endpackage

// File: rtl/gpev_sync.sv
module gpev_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
  import gpev_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] cur_i,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] chg_i,
  input  logic [N_PINS-1:0] pol_i,
  output logic [N_PINS-1:0] evt_o
);

  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    assign evt_o[p] = pin_event(cur_i[p], prev_q[p], lvl_i[p], chg_i[p], pol_i[p]);
  end

  // an edge-mode event needs the sample to have moved (R3, R4)
  assert_edge_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~lvl_i & ~(cur_i ^ prev_q)) == '0));

  // a level-mode event needs the sample to match the polarity (R5)
  assert_level_matches_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & lvl_i & (cur_i ^ pol_i)) == '0));

  // in change mode any movement is an event (R4)
  assert_change_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~evt_o & ~lvl_i & chg_i & (cur_i ^ prev_q)) == '0));

endmodule

// File: rtl/gpev_regs.sv
module gpev_regs
  import gpev_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [N_PINS-1:0] wdata_i,
  input  logic [N_PINS-1:0] evt_i,
  output logic [N_PINS-1:0] rdata_o,
  output logic [N_PINS-1:0] ien_o,
  output logic [N_PINS-1:0] pend_o,
  output logic [N_PINS-1:0] chg_o,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] pol_o,
  output logic [N_PINS-1:0] wake_o
);

  localparam int unsigned LOW_W  = $clog2(REG_STRIDE);
  localparam int unsigned SLOT_W = ADDR_W - LOW_W;

  logic [SLOT_W-1:0]   slot;
  logic                aligned;
  logic [NUM_REGS-1:0] sel;
  logic [N_PINS-1:0]   ctl_q [NUM_REGS];
  logic                pend_wr;
  logic [N_PINS-1:0]   clr_mask;

  assign slot    = addr_i[ADDR_W-1:LOW_W];
  assign aligned = (addr_i[LOW_W-1:0] == '0);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    assign sel[r] = aligned && (slot == SLOT_W'(r));
    if (r == IDX_PEND) begin : g_sticky
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q[r] <= '0;
        else        ctl_q[r] <= (ctl_q[r] & ~clr_mask) | evt_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ctl_q[r] <= '0;
        else if (wr_i && sel[r]) ctl_q[r] <= wdata_i;
      end
    end
  end

  assign pend_wr  = wr_i && sel[IDX_PEND];
  assign clr_mask = pend_wr ? wdata_i : '0;

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (sel[r]) rdata_o = ctl_q[r];
    end
  end

  assign ien_o  = ctl_q[IDX_IEN];
  assign pend_o = ctl_q[IDX_PEND];
  assign chg_o  = ctl_q[IDX_CHG];
  assign lvl_o  = ctl_q[IDX_LVL];
  assign pol_o  = ctl_q[IDX_POL];
  assign wake_o = ctl_q[IDX_WAKE];

  // a detected event is always latched, enable or not, even against a clear (R6, R7)
  assert_evt_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

  // written ones without a competing event leave the bit clear (R6)
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && ((wdata_i & ~evt_i) != '0)) |=> ((pend_o & $past(wdata_i & ~evt_i)) == '0));

  // without a pending write no bit ever drops (R6)
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  // at most one word is selected by any address (R2)
  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: rtl/gpev_top.sv
module gpev_top
  import gpev_pkg::*;
#(
  parameter int unsigned N_PINS   = 32,
  parameter int unsigned GRP_PINS = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned N_GRP   = N_PINS / GRP_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  output logic [N_GRP-1:0]  irq_req,
  output logic              wake_req
);

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] evt;
  logic [N_PINS-1:0] ien, pend, chg, lvl, pol, wake_en;

  gpev_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STG)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpev_detect #(.N_PINS(N_PINS)) detect_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i (pin_sync),
    .lvl_i (lvl),
    .chg_i (chg),
    .pol_i (pol),
    .evt_o (evt)
  );

  gpev_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .wdata_i (bus_wdata),
    .evt_i   (evt),
    .rdata_o (bus_rdata),
    .ien_o   (ien),
    .pend_o  (pend),
    .chg_o   (chg),
    .lvl_o   (lvl),
    .pol_o   (pol),
    .wake_o  (wake_en)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_irq
    assign irq_req[g] = |(pend[g*GRP_PINS +: GRP_PINS] & ien[g*GRP_PINS +: GRP_PINS]);

    // a group line needs an enabled pin in that group (R8)
    assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[g] |-> (ien[g*GRP_PINS +: GRP_PINS] != '0));
  end

  assign wake_req = |(pend & wake_en);

  // wake needs some pin allowed to wake (R9)
  assert_wake_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_en != '0));

  // wake needs something pending (R9)
  assert_wake_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pend != '0));

endmodule

// File: tb/gpev_top_tb.sv
module gpev_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_IEN = 8'h00, A_PEND = 8'h10, A_CHG = 8'h20,
                         A_LVL = 8'h30, A_POL = 8'h40, A_WAKE = 8'h50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_req;
  logic        wake_req;

  int n_checks = 0;
  int n_errs   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpev_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pins),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .wake_req  (wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pins = v;
  endtask

  // falling edge on the masked pins; their rules are assumed to be all-zero
  task automatic fall_event(input logic [31:0] m);
    set_pins(pins | m);
    wait_cyc(4);
    set_pins(pins & ~m);
    wait_cyc(4);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[i]) begin end
    for (int r = 0; r < 6; r++) begin
      rd(8'(r * 16), v);
      chk("R1 word after reset", v, 32'h0);
    end
    chk("R1 irq after reset", {30'h0, irq_req}, 32'h0);
    chk("R1 wake after reset", {31'h0, wake_req}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(A_IEN, 32'hA5A5_0F0F);
    wr(A_CHG, 32'h1234_5678);
    wr(A_POL, 32'hFFFF_FFFF);   // pins low, so a later level setting finds no active level
    wr(A_LVL, 32'h0F0F_F0F0);
    wr(A_WAKE, 32'h8000_0001);
    rd(A_IEN, v);  chk("R2 enable readback", v, 32'hA5A5_0F0F);
    rd(A_CHG, v);  chk("R2 change readback", v, 32'h1234_5678);
    rd(A_POL, v);  chk("R2 polarity readback", v, 32'hFFFF_FFFF);
    rd(A_LVL, v);  chk("R2 level readback", v, 32'h0F0F_F0F0);
    rd(A_WAKE, v); chk("R2 wake readback", v, 32'h8000_0001);
    wr(8'h60, 32'hDEAD_BEEF);
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'h60, v);  chk("R2 unused 0x60 reads zero", v, 32'h0);
    rd(8'h08, v);  chk("R2 unaligned 0x08 reads zero", v, 32'h0);
    rd(A_IEN, v);  chk("R2 enable untouched by stray write", v, 32'hA5A5_0F0F);
    rd(A_CHG, v);  chk("R2 change untouched by stray write", v, 32'h1234_5678);
    wr(A_IEN, 0); wr(A_CHG, 0); wr(A_LVL, 0); wr(A_POL, 0); wr(A_WAKE, 0);
    wr(A_PEND, 32'hFFFF_FFFF);
    rd(A_PEND, v); chk("R2 pending clear after setup", v, 32'h0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    set_pins(32'h0010_0008);          // rising on 3 and 20, falling rule: nothing
    wait_cyc(4);
    rd(A_PEND, v); chk("R3 rising ignored in falling mode", v, 32'h0);
    set_pins(32'h0010_0000);          // falling on pin 3
    wait_cyc(2);
    rd(A_PEND, v); chk("R10 not yet visible after two edges", v, 32'h0);
    wait_cyc(1);
    rd(A_PEND, v); chk("R10 visible after third edge", v, 32'h0000_0008);
    wr(A_POL, 32'h0010_0000);
    wr(A_PEND, 32'hFFFF_FFFF);
    set_pins(32'h0);                  // falling on pin 20 with rising rule
    wait_cyc(4);
    rd(A_PEND, v); chk("R3 falling ignored in rising mode", v, 32'h0);
    set_pins(32'h0010_0000);
    wait_cyc(4);
    rd(A_PEND, v); chk("R3 rising detected", v, 32'h0010_0000);
    set_pins(32'h0);
    wr(A_POL, 0);
    wait_cyc(4);
    wr(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic t_change;
    logic [31:0] v;
    wr(A_CHG, 32'h0000_0020);
    wr(A_POL, 32'h0000_0020);
    set_pins(32'h0000_0020);
    wait_cyc(4);
    rd(A_PEND, v); chk("R4 change mode rising", v, 32'h0000_0020);
    wr(A_PEND, 32'h0000_0020);
    rd(A_PEND, v); chk("R4 cleared between edges", v, 32'h0);
    set_pins(32'h0);
    wait_cyc(4);
    rd(A_PEND, v); chk("R4 change mode falling despite polarity", v, 32'h0000_0020);
    wr(A_CHG, 0); wr(A_POL, 0);
    wr(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(A_POL, 32'h0000_0100);
    wr(A_LVL, 32'h0000_0100);
    wait_cyc(2);
    rd(A_PEND, v); chk("R5 inactive level sets nothing", v, 32'h0);
    set_pins(32'h0000_0100);
    wait_cyc(4);
    rd(A_PEND, v); chk("R5 high level detected", v, 32'h0000_0100);
    wr(A_PEND, 32'h0000_0100);
    rd(A_PEND, v); chk("R6 set wins over clear while level holds", v, 32'h0000_0100);
    set_pins(32'h0);
    wait_cyc(4);
    wr(A_PEND, 32'h0000_0100);
    rd(A_PEND, v); chk("R5 clears once level gone", v, 32'h0);
    wr(A_POL, 32'h0);                 // now low is the active level
    wait_cyc(2);
    rd(A_PEND, v); chk("R5 low level detected", v, 32'h0000_0100);
    wr(A_LVL, 0);
    wait_cyc(1);
    wr(A_PEND, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    fall_event(32'h0000_0003);
    rd(A_PEND, v); chk("R6 two pins pending", v, 32'h0000_0003);
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); chk("R6 zero write keeps bits", v, 32'h0000_0003);
    wr(A_PEND, 32'h0000_0001);
    rd(A_PEND, v); chk("R6 one write clears bit 0 only", v, 32'h0000_0002);
    wr(A_PEND, 32'h0000_0002);
    rd(A_PEND, v); chk("R6 one write clears bit 1", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    fall_event(32'h0000_0004);
    rd(A_PEND, v); chk("R7 latched with enable off", v, 32'h0000_0004);
    chk("R8 no irq without enable", {30'h0, irq_req}, 32'h0);
    wr(A_IEN, 32'h0000_0004);
    chk("R8 low group irq", {30'h0, irq_req}, 32'h1);
    fall_event(32'h0002_0000);
    chk("R8 high group waits for enable", {30'h0, irq_req}, 32'h1);
    wr(A_IEN, 32'h0002_0004);
    chk("R8 both groups", {30'h0, irq_req}, 32'h3);
    wr(A_PEND, 32'h0000_0004);
    chk("R8 low group drops on clear", {30'h0, irq_req}, 32'h2);
  endtask

  task automatic t_wake;
    wr(A_WAKE, 32'h0002_0000);
    chk("R9 wake from pending pin 17", {31'h0, wake_req}, 32'h1);
    wr(A_WAKE, 32'h0000_0010);
    chk("R9 no wake from idle pin", {31'h0, wake_req}, 32'h0);
    wr(A_WAKE, 32'h0002_0000);
    wr(A_PEND, 32'hFFFF_FFFF);
    chk("R9 wake drops with pending", {31'h0, wake_req}, 32'h0);
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_edge();
    t_change();
    t_level();
    t_w1c();
    t_irq();
    t_wake();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

endmodule